// File: doc/BRIEF.md
# Banked Digital I/O with Edge Capture

This block gives a register-mapped host access to a set of general-purpose digital lines grouped into banks of sixteen. Through each bank's registers the host reads the synchronized input levels, sets the output levels, and, per channel, picks which edge direction to watch, turns edge capture on or off and turns the interrupt contribution on or off. Edges seen on a watched channel set a sticky flag that the host reads back. The flag read and the output-level write share one register location.

Capture is gated twice. Each channel has its own capture enable, and one global enable bit in a separate control register stops all capture activity when it is cleared. Only the first channels in the numbering (forty by default) carry capture and interrupt logic. The remaining channels are plain inputs and outputs. A single interrupt line is raised while any captured flag has its interrupt enable set.

The host clears a flag by writing a zero to that channel's capture enable. It then writes a one again to re-arm the channel. All host-visible outputs are registered, and inputs pass through a two-flop synchronizer before edge detection.

Top module: `dio_capture_banks`

## Requirements
- R1: After a synchronous reset, pin_out, irq and rdata are zero, and every enable, edge-select, flag and the global capture enable read back as zero.
- R2: Bank b occupies addresses 0x40 + 0x10*b. Offset 0x2 writes the interrupt enables, 0x4 writes the edge selects and 0x6 writes the capture enables. Offset 0x0 reads input levels, 0x8 reads captured flags, and 0xA, 0xC and 0xE read back the interrupt enables, edge selects and capture enables. rdata takes the addressed value on the clock edge where rd_en is high and holds it otherwise. Unmapped or odd addresses read 0.
- R3: A write to bank offset 0x8 sets that bank's sixteen output levels on pin_out at the same clock edge and leaves the captured flags unchanged. pin_out changes only on a write.
- R4: An input-level read returns the pin values present at least two clock edges before the edge that samples the read, after a two-flop synchronizer.
- R5: An edge-select bit of 1 captures rising edges and 0 captures falling edges. An edge in the other direction sets no flag.
- R6: A channel whose capture-enable bit is 0 never sets its flag.
- R7: Bit 12 of the control register at address 0x88 is the global capture enable. It is read/write, and its other bits read 0. While it is 0, no flag sets.
- R8: A flag stays set until a write of 0 to that channel's capture-enable bit. Writing 1 keeps the flag. A clear and a new edge in the same cycle leave the flag clear.
- R9: A flag reads as set after the third rising clock edge following a pin change, and irq follows on the fourth.
- R10: irq is a register holding the OR over all channels of flag AND interrupt enable, as it stood one clock earlier.
- R11: Channels 40 to 47 (bank 2, bits 8 to 15) are plain. Their enables and edge selects read 0 and their flags never set, while their input reads and output writes work normally.
- R12: Channel n maps to bank n/16, bit n%16 of the bank registers and to bit n of pin_in and pin_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pin_in | input | 48 | Asynchronous input levels, one per channel |
| pin_out | output | 48 | Registered output levels, one per channel |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: three banks of sixteen, forty capture-capable channels, a two-stage synchronizer, bank base 0x40 and control register 0x88. Because forty is not a multiple of sixteen, the last bank holds both capture-capable and plain channels, so the split between the two kinds of channel is exercised inside one bank. With the two-stage setting, the exact three- and four-edge latencies of flag and interrupt can be checked cycle by cycle against the reference model.

// File: rtl/dio_capture_pkg.sv
package dio_capture_pkg;

  // Bank-local register offsets; the 16-byte bank pitch is fixed by this width.
  localparam int OFF_W = 4;

  typedef enum logic [OFF_W-1:0] {
    OFF_LEVEL    = 4'h0,
    OFF_IRQEN_WR = 4'h2,
    OFF_EDGE_WR  = 4'h4,
    OFF_CAPEN_WR = 4'h6,
    OFF_FLAG_OUT = 4'h8,
    OFF_IRQEN_RB = 4'hA,
    OFF_EDGE_RB  = 4'hC,
    OFF_CAPEN_RB = 4'hE
  } dio_off_e;

  // Number of capture-capable channels inside a given bank.
  function automatic int ext_in_bank(int bank, int width, int ext_total);
    if (ext_total <= bank * width) return 0;
    else if (ext_total >= (bank + 1) * width) return width;
    else return ext_total - bank * width;
  endfunction

endpackage

// File: rtl/dio_input_sync.sv
module dio_input_sync #(
  parameter int WIDTH  = 48,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] level_d
);

  // STAGES synchronizer flops plus one history flop for edge detection.
  localparam int DEPTH = STAGES + 1;

  logic [WIDTH-1:0] chain_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= pin_in;
      for (int s = 1; s < DEPTH; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign level   = chain_q[STAGES-1];
  assign level_d = chain_q[STAGES];

endmodule

// File: rtl/dio_bank.sv
module dio_bank
  import dio_capture_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int EXT_BITS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gcap,
  input  logic             wr_stb,
  input  logic [OFF_W-1:0] off,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] level_d,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] rd_word,
  output logic [WIDTH-1:0] flags,
  output logic [WIDTH-1:0] irq_en
);

  // Low EXT_BITS channels carry capture logic; the rest stay constant zero.
  localparam logic [WIDTH-1:0] EXT_MASK = {WIDTH{1'b1}} >> (WIDTH - EXT_BITS);

  logic [WIDTH-1:0] ie_q, es_q, ce_q, fl_q, dout_q;
  logic [WIDTH-1:0] rise, fall, hit, clr, fl_next;

  assign rise = level & ~level_d;
  assign fall = ~level & level_d;
  assign hit  = ((es_q & rise) | (~es_q & fall)) & ce_q & {WIDTH{gcap}};

  // Writing 0 to a capture-enable bit drops the flag; clear beats a new edge.
  always_comb begin
    clr = '0;
    if (wr_stb && off == OFF_CAPEN_WR) clr = ~wdata;
    fl_next = (fl_q | hit) & ~clr & EXT_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= '0;
      es_q   <= '0;
      ce_q   <= '0;
      fl_q   <= '0;
      dout_q <= '0;
    end else begin
      fl_q <= fl_next;
      if (wr_stb) begin
        case (off)
          OFF_IRQEN_WR: ie_q   <= wdata & EXT_MASK;
          OFF_EDGE_WR:  es_q   <= wdata & EXT_MASK;
          OFF_CAPEN_WR: ce_q   <= wdata & EXT_MASK;
          OFF_FLAG_OUT: dout_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (off)
      OFF_LEVEL:    rd_word = level;
      OFF_FLAG_OUT: rd_word = fl_q;
      OFF_IRQEN_RB: rd_word = ie_q;
      OFF_EDGE_RB:  rd_word = es_q;
      OFF_CAPEN_RB: rd_word = ce_q;
      default:      rd_word = '0;
    endcase
  end

  assign dout   = dout_q;
  assign flags  = fl_q;
  assign irq_en = ie_q;

endmodule

// File: rtl/dio_capture_banks.sv
module dio_capture_banks
  import dio_capture_pkg::*;
#(
  parameter int NUM_BANKS    = 3,
  parameter int BANK_WIDTH   = 16,
  parameter int EXT_CHANNELS = 40,
  parameter int SYNC_STAGES  = 2,
  parameter int ADDR_W       = 8,
  parameter int BANK_BASE    = 'h40,
  parameter int CTRL_ADDR    = 'h88,
  parameter int GCAP_BIT     = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [BANK_WIDTH-1:0]           wdata,
  output logic [BANK_WIDTH-1:0]           rdata,
  input  logic [NUM_BANKS*BANK_WIDTH-1:0] pin_in,
  output logic [NUM_BANKS*BANK_WIDTH-1:0] pin_out,
  output logic                            irq
);

  localparam int NCH   = NUM_BANKS * BANK_WIDTH;
  localparam int IDX_W = ADDR_W - OFF_W;

  logic [NCH-1:0]        lvl, lvl_d, flag_all, ie_all;
  logic [ADDR_W-1:0]     rel;
  logic [IDX_W-1:0]      bank_idx;
  logic [OFF_W-1:0]      off;
  logic                  in_range, ctrl_hit, gcap_q;
  logic [BANK_WIDTH-1:0] bank_rd [NUM_BANKS];
  logic [BANK_WIDTH-1:0] rd_mux;

  dio_input_sync #(
    .WIDTH (NCH),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_in (pin_in),
    .level  (lvl),
    .level_d(lvl_d)
  );

  // Address decode: bank index above the offset field, offset below.
  assign rel      = addr - ADDR_W'(BANK_BASE);
  assign bank_idx = rel[ADDR_W-1:OFF_W];
  assign off      = rel[OFF_W-1:0];
  assign in_range = (addr >= ADDR_W'(BANK_BASE)) && (bank_idx < IDX_W'(NUM_BANKS));
  assign ctrl_hit = (addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (rst) gcap_q <= 1'b0;
    else if (wr_en && ctrl_hit) gcap_q <= wdata[GCAP_BIT];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int EXT_B = ext_in_bank(b, BANK_WIDTH, EXT_CHANNELS);
    logic sel;
    assign sel = in_range && (bank_idx == IDX_W'(b));

    dio_bank #(
      .WIDTH   (BANK_WIDTH),
      .EXT_BITS(EXT_B)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .gcap   (gcap_q),
      .wr_stb (wr_en && sel),
      .off    (off),
      .wdata  (wdata),
      .level  (lvl[b*BANK_WIDTH +: BANK_WIDTH]),
      .level_d(lvl_d[b*BANK_WIDTH +: BANK_WIDTH]),
      .dout   (pin_out[b*BANK_WIDTH +: BANK_WIDTH]),
      .rd_word(bank_rd[b]),
      .flags  (flag_all[b*BANK_WIDTH +: BANK_WIDTH]),
      .irq_en (ie_all[b*BANK_WIDTH +: BANK_WIDTH])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) begin
      rd_mux[GCAP_BIT] = gcap_q;
    end else if (in_range) begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (bank_idx == IDX_W'(b)) rd_mux = bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= |(flag_all & ie_all);
    end
  end

endmodule

// File: rtl/dio_capture_checker.sv
module dio_capture_checker #(
  parameter int NCH       = 48,
  parameter int ADDR_W    = 8,
  parameter int BANK_BASE = 'h40
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NCH-1:0]    pin_out,
  input logic              irq,
  input logic              gcap,
  input logic [NCH-1:0]    flags,
  input logic [NCH-1:0]    irq_en
);

  logic [3:0] rel_lo;
  logic       capen_addr;

  assign rel_lo     = addr[3:0] - 4'(BANK_BASE);
  assign capen_addr = (addr >= ADDR_W'(BANK_BASE)) && (rel_lo == 4'h6);

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && !irq));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(pin_out));

  assert_gcap_off_R7: assert property (@(posedge clk) disable iff (rst)
    !gcap |=> ((flags & ~$past(flags)) == '0));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (|($past(flags) & ~flags)) |-> ($past(wr_en) && $past(capen_addr)));

  assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(flags & irq_en)));

endmodule

bind dio_capture_banks dio_capture_checker #(
  .NCH      (NUM_BANKS * BANK_WIDTH),
  .ADDR_W   (ADDR_W),
  .BANK_BASE(BANK_BASE)
) i_checker (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .addr   (addr),
  .pin_out(pin_out),
  .irq    (irq),
  .gcap   (gcap_q),
  .flags  (flag_all),
  .irq_en (ie_all)
);

// File: tb/test_dio_capture_banks.sv
module test_dio_capture_banks;

  localparam int NCH  = 48;
  localparam int EXT  = 40;
  localparam int CTRL = 'h88;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  dio_capture_banks i_dio_capture_banks (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, one update per rising edge.
  logic [47:0] m_s1, m_s2, m_prev, m_out, m_ie, m_es, m_ce, m_fl, nf;
  logic        m_g, m_irq, nirq;
  logic [15:0] m_rd;
  int          wa, wbk, wof, wch;

  function automatic logic [15:0] m_read(input int a);
    logic [15:0] v;
    int bk, of;
    v = '0;
    if (a == CTRL) v[12] = m_g;
    else if (a >= 'h40 && a < 'h70) begin
      bk = (a - 'h40) / 16;
      of = (a - 'h40) % 16;
      case (of)
        0:  v = m_s2[bk*16 +: 16];
        8:  v = m_fl[bk*16 +: 16];
        10: v = m_ie[bk*16 +: 16];
        12: v = m_es[bk*16 +: 16];
        14: v = m_ce[bk*16 +: 16];
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_out = '0; m_ie = '0;
      m_es = '0; m_ce = '0; m_fl = '0; m_g = 1'b0; m_irq = 1'b0; m_rd = '0;
    end else begin
      nf = m_fl;
      for (int ch = 0; ch < NCH; ch++) begin
        if (ch < EXT && m_g && m_ce[ch]) begin
          if (m_es[ch] && m_s2[ch] && !m_prev[ch]) nf[ch] = 1'b1;
          if (!m_es[ch] && !m_s2[ch] && m_prev[ch]) nf[ch] = 1'b1;
        end
      end
      nirq = |(m_fl & m_ie);
      if (rd_en) m_rd = m_read(int'(addr));
      if (wr_en) begin
        wa = int'(addr);
        if (wa == CTRL) m_g = wdata[12];
        else if (wa >= 'h40 && wa < 'h70) begin
          wbk = (wa - 'h40) / 16;
          wof = (wa - 'h40) % 16;
          for (int i = 0; i < 16; i++) begin
            wch = wbk * 16 + i;
            case (wof)
              2: m_ie[wch] = (wch < EXT) && wdata[i];
              4: m_es[wch] = (wch < EXT) && wdata[i];
              6: begin
                m_ce[wch] = (wch < EXT) && wdata[i];
                if (!wdata[i]) nf[wch] = 1'b0;
              end
              8: m_out[wch] = wdata[i];
              default: ;
            endcase
          end
        end
      end
      m_fl = nf; m_irq = nirq;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 pin_out vs model", pin_out, m_out);
      chk("R10 irq vs model", 48'(irq), 48'(m_irq));
      chk("R2 rdata vs model", 48'(rdata), 48'(m_rd));
    end
  end

  always @(posedge clk) begin
    if (cycles == 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    // R1: reset state
    chk("R1 pin_out after reset", pin_out, 48'h0);
    chk("R1 irq after reset", 48'(irq), 48'h0);
    chk("R1 rdata after reset", 48'(rdata), 48'h0);
    do_read(8'h88, rv); chk("R1 global enable reset", 48'(rv), 48'h0);
    do_read(8'h4E, rv); chk("R1 capture enable reset", 48'(rv), 48'h0);

    // R7: global enable bit 12
    do_write(8'h88, 16'hFFFF);
    do_read(8'h88, rv); chk("R7 control readback", 48'(rv), 48'h1000);

    // R2: bank 0 configuration and readback
    do_write(8'h42, 16'h0001);
    do_write(8'h44, 16'h00FF);
    do_write(8'h46, 16'h0F0F);
    do_read(8'h4A, rv); chk("R2 irq enable readback", 48'(rv), 48'h0001);
    do_read(8'h4C, rv); chk("R2 edge select readback", 48'(rv), 48'h00FF);
    do_read(8'h4E, rv); chk("R2 capture enable readback", 48'(rv), 48'h0F0F);

    // R9: latency from pin change to flag and irq
    @(negedge clk); pin_in[15:0] = 16'hFFFF;
    idle(3); chk("R9 irq low after third edge", 48'(irq), 48'h0);
    idle(1); chk("R9 irq high after fourth edge", 48'(irq), 48'h1);
    do_read(8'h40, rv); chk("R4 input level high", 48'(rv), 48'hFFFF);
    do_read(8'h48, rv); chk("R5 R6 rising captured", 48'(rv), 48'h000F);

    // R5: falling edges on bits 8..15
    @(negedge clk); pin_in[15:0] = 16'h0000;
    idle(5);
    do_read(8'h48, rv); chk("R5 R8 falling captured, sticky", 48'(rv), 48'h0F0F);
    do_read(8'h40, rv); chk("R4 input level low", 48'(rv), 48'h0000);

    // R8: clear by writing capture enable 0, keep with 1
    do_write(8'h46, 16'h0F0E);
    do_read(8'h48, rv); chk("R8 flag cleared", 48'(rv), 48'h0F0E);
    chk("R10 irq dropped", 48'(irq), 48'h0);
    do_write(8'h46, 16'h0F0F);
    do_read(8'h48, rv); chk("R8 writing 1 keeps flags", 48'(rv), 48'h0F0E);

    // R3: output write shares flag address
    do_write(8'h48, 16'hA5A5);
    chk("R3 output bank0", 48'(pin_out[15:0]), 48'hA5A5);
    do_read(8'h48, rv); chk("R3 flags untouched by output write", 48'(rv), 48'h0F0E);

    // R7: global enable gates capture (bank 1)
    do_write(8'h88, 16'h0000);
    do_write(8'h54, 16'hFFFF);
    do_write(8'h56, 16'hFFFF);
    @(negedge clk); pin_in[31:16] = 16'hFFFF;
    idle(5);
    do_read(8'h58, rv); chk("R7 no capture while disabled", 48'(rv), 48'h0);
    do_write(8'h88, 16'h1000);
    @(negedge clk); pin_in[31:16] = 16'h0000;
    idle(5);
    do_read(8'h58, rv); chk("R5 opposite edge ignored", 48'(rv), 48'h0);
    @(negedge clk); pin_in[31:16] = 16'hFFFF;
    idle(5);
    do_read(8'h58, rv); chk("R7 R12 capture when enabled bank1", 48'(rv), 48'hFFFF);

    // R11: plain channels in bank 2
    do_write(8'h62, 16'hFFFF);
    do_write(8'h64, 16'hFFFF);
    do_write(8'h66, 16'hFFFF);
    do_read(8'h6A, rv); chk("R11 plain irq enable reads 0", 48'(rv), 48'h00FF);
    do_read(8'h6E, rv); chk("R11 plain capture enable reads 0", 48'(rv), 48'h00FF);
    @(negedge clk); pin_in[47:32] = 16'hFFFF;
    idle(5);
    do_read(8'h68, rv); chk("R11 plain flags never set", 48'(rv), 48'h00FF);
    do_read(8'h60, rv); chk("R11 plain inputs readable", 48'(rv), 48'hFFFF);
    chk("R10 irq from bank2", 48'(irq), 48'h1);
    do_write(8'h68, 16'hFFFF);
    chk("R11 plain outputs driven", 48'(pin_out[47:32]), 48'hFFFF);

    // R12: bank 1 output mapping
    do_write(8'h58, 16'h1234);
    chk("R12 bank1 output bits 16..31", 48'(pin_out[31:16]), 48'h1234);

    // R2: unmapped and odd addresses
    do_read(8'h30, rv); chk("R2 unmapped low", 48'(rv), 48'h0);
    do_read(8'h41, rv); chk("R2 odd offset", 48'(rv), 48'h0);
    do_read(8'h70, rv); chk("R2 past last bank", 48'(rv), 48'h0);

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule